// File: doc/BRIEF.md
# Serial Register-Access Slave Port

This block is the slave side of a synchronous serial link. An external host drives a serial clock, a single data line and an optional active-low select. Every exchange opens with an 8-bit instruction byte. That byte chooses a read or a write, a length of one to three bytes and a start location in a sixteen-entry byte map. The map holds four registers: a 16-bit data word, a 16-bit command word, and two 24-bit calibration words (offset and full-scale). The block moves the data bytes and steps the location after each byte. It turns the data line around for reads and abandons any exchange that stalls.

The serial clock, select and data line are brought into the system clock domain through synchronizers. Edges are detected there. The system clock must run at least about ten times faster than the serial clock. The bidirectional pad sits outside the block and is driven from a data output and an output-enable. All four registers appear as parallel output words for the logic around the block. Two bits of the command word set the transfer order of later exchanges: one makes the address step downward and the other makes data bytes travel least-significant bit first.

Top module: `sreg_port_slave`

## Requirements
- R1: The instruction byte always arrives MSB first, whatever the order settings. Its bit 7 selects read (1) or write (0). Bits 6:5 give the length: 00 means 1 byte, 01 means 2, 10 means 3, and 11 is handled as 3. Bit 4 is ignored. Bits 3:0 give the start location.
- R2: The byte map is as follows. Location 0 is data_word[15:8] and 1 is data_word[7:0]. Location 4 is cmd_word[15:8] and 5 is cmd_word[7:0]. Locations 8, 9 and 10 are ofs_word[23:16], [15:8] and [7:0]. Locations 12, 13 and 14 are fsc_word[23:16], [15:8] and [7:0]. Writes to any other location are discarded, and reads from them return 0.
- R3: After each data byte the location rises by one when cmd_word[2] is 0 and falls by one when it is 1. It wraps modulo 16.
- R4: When cmd_word[3] is 1, each data byte is sent and received least-significant bit first. When it is 0, each data byte is sent and received most-significant bit first.
- R5: Input bits are taken on the falling serial-clock edge. Read data changes only after a rising edge. The first read bit is presented as soon as the instruction byte completes.
- R6: Written bytes reach the registers only after the falling edge of the last bit of the last byte. No register changes earlier in an exchange.
- R7: An exchange may sit for TIMEOUT_CYC system clocks with no accepted serial edge. The exchange is then abandoned: staged bytes are dropped, the registers keep their values, the data line is released, and the next bit starts a new instruction byte.
- R8: sdio_oe is high only during the data phase of a read. It falls after the last falling edge of that read. Raising cs_n during a read does not lower it.
- R9: While cs_n is high, serial clock edges are ignored.
- R10: While rst is high and after it falls, all four register words and sdio_oe are 0, and the port waits for an instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low select; tie low for a two-wire link |
| sdio_in | input | 1 | Data line as seen at the pad |
| sdio_out | output | 1 | Read data driven toward the pad |
| sdio_oe | output | 1 | Pad output enable |
| data_word | output | 16 | Data register |
| cmd_word | output | 16 | Command register (bit 3 LSB-first, bit 2 address-down) |
| ofs_word | output | 24 | Offset calibration register |
| fsc_word | output | 24 | Full-scale calibration register |

## Verification
The bench builds the block with TIMEOUT_CYC at 300 and two synchronizer stages. The bench serial clock is 16 system clocks per bit. With these values a deliberate stall of a few hundred cycles expires the timeout, while normal bit spacing never comes near it. Random exchanges also rewrite the command word. This mixes the address directions and the bit orders with every length, with wrap past location 15, and with reserved locations.

// File: rtl/sreg_pkg.sv
package sreg_pkg;
  localparam int ADDR_W   = 4;
  localparam int NLOC     = 1 << ADDR_W;
  localparam int BYTE_W   = 8;
  localparam int MAX_XFER = 3;
  localparam int IDX_W    = $clog2(MAX_XFER);
  localparam int BIT_W    = $clog2(BYTE_W);

  localparam int CMD_LSB_FIRST = 3;
  localparam int CMD_ADDR_DOWN = 2;

  typedef enum logic {PH_INSTR, PH_DATA} phase_e;

  function automatic logic loc_mapped(input logic [ADDR_W-1:0] a);
    case (a)
      4'd0, 4'd1, 4'd4, 4'd5, 4'd8, 4'd9, 4'd10, 4'd12, 4'd13, 4'd14: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [1:0] xfer_len(input logic [1:0] f);
    return (f == 2'b11) ? 2'd3 : f + 2'd1;
  endfunction
endpackage

// File: rtl/sreg_sync.sv
module sreg_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sclk,
  input  logic cs_n,
  input  logic sdio_in,
  output logic rise,
  output logic fall,
  output logic din
);
  logic [STAGES-1:0] s_clk, s_cs, s_dat;
  logic prev_clk;

  always_ff @(posedge clk) begin
    if (rst) begin
      s_clk    <= '0;
      s_cs     <= '1;
      s_dat    <= '0;
      prev_clk <= 1'b0;
    end else begin
      s_clk    <= {s_clk[STAGES-2:0], sclk};
      s_cs     <= {s_cs[STAGES-2:0], cs_n};
      s_dat    <= {s_dat[STAGES-2:0], sdio_in};
      prev_clk <= s_clk[STAGES-1];
    end
  end

  assign rise = !s_cs[STAGES-1] &&  s_clk[STAGES-1] && !prev_clk;
  assign fall = !s_cs[STAGES-1] && !s_clk[STAGES-1] &&  prev_clk;
  assign din  = s_dat[STAGES-1];
endmodule

// File: rtl/sreg_stall_timer.sv
module sreg_stall_timer #(
  parameter int LIMIT = 250000,
  localparam int CNT_W = $clog2(LIMIT + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             busy,
  input  logic             edge_seen,
  output logic             abort,
  output logic [CNT_W-1:0] cnt
);
  assign abort = busy && !edge_seen && (cnt == CNT_W'(LIMIT - 1));

  always_ff @(posedge clk) begin
    if (rst || !busy || edge_seen || abort) cnt <= '0;
    else                                    cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/sreg_engine.sv
module sreg_engine
  import sreg_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              rise,
  input  logic              fall,
  input  logic              din,
  input  logic              abort,
  input  logic              lsb_first,
  input  logic              addr_down,
  input  logic [BYTE_W-1:0] rd_byte,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              st_we,
  output logic [IDX_W-1:0]  st_idx,
  output logic [ADDR_W-1:0] st_addr,
  output logic [BYTE_W-1:0] st_data,
  output logic              commit,
  output logic              drop,
  output logic              busy,
  output logic              sdio_out,
  output logic              sdio_oe
);
  phase_e            phase;
  logic [BIT_W-1:0]  bit_cnt;
  logic [BYTE_W-1:0] shreg;
  logic              is_read;
  logic [1:0]        left;
  logic [IDX_W-1:0]  idx;
  logic [ADDR_W-1:0] addr;
  logic              load_q, pend_commit;

  logic [BIT_W-1:0]  bit_sel;
  logic [BYTE_W-1:0] data_byte;
  logic [ADDR_W-1:0] next_addr;
  logic              last_bit;

  assign bit_sel   = lsb_first ? bit_cnt : BIT_W'(BYTE_W - 1) - bit_cnt;
  assign data_byte = lsb_first ? {din, shreg[BYTE_W-1:1]} : {shreg[BYTE_W-2:0], din};
  assign next_addr = addr_down ? addr - 1'b1 : addr + 1'b1;
  assign last_bit  = (bit_cnt == BIT_W'(BYTE_W - 1));
  assign rd_addr   = addr;
  assign busy      = (phase == PH_DATA) || (bit_cnt != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_INSTR; bit_cnt <= '0; shreg <= '0; is_read <= 1'b0;
      left <= '0; idx <= '0; addr <= '0; load_q <= 1'b0; pend_commit <= 1'b0;
      st_we <= 1'b0; st_idx <= '0; st_addr <= '0; st_data <= '0;
      commit <= 1'b0; drop <= 1'b0; sdio_out <= 1'b0; sdio_oe <= 1'b0;
    end else begin
      st_we       <= 1'b0;
      drop        <= 1'b0;
      load_q      <= 1'b0;
      pend_commit <= 1'b0;
      commit      <= pend_commit;
      if (abort) begin
        phase   <= PH_INSTR;
        bit_cnt <= '0;
        sdio_oe <= 1'b0;
        drop    <= 1'b0 | 1'b1;
      end else if (fall) begin
        bit_cnt <= bit_cnt + 1'b1;
        if (phase == PH_INSTR) begin
          shreg <= {shreg[BYTE_W-2:0], din};
          if (last_bit) begin
            phase   <= PH_DATA;
            is_read <= shreg[6];
            left    <= xfer_len(shreg[5:4]);
            addr    <= {shreg[2:0], din};
            idx     <= '0;
            if (shreg[6]) begin
              sdio_oe <= 1'b1;
              load_q  <= 1'b1;
            end
          end
        end else begin
          shreg <= data_byte;
          if (last_bit) begin
            if (!is_read) begin
              st_we   <= 1'b1;
              st_idx  <= idx;
              st_addr <= addr;
              st_data <= data_byte;
            end
            idx  <= idx + 1'b1;
            addr <= next_addr;
            left <= left - 1'b1;
            if (left == 2'd1) begin
              phase       <= PH_INSTR;
              sdio_oe     <= 1'b0;
              pend_commit <= !is_read;
            end
          end
        end
      end else if (load_q || (rise && sdio_oe && phase == PH_DATA)) begin
        sdio_out <= rd_byte[bit_sel];
      end
    end
  end
endmodule

// File: rtl/sreg_bank.sv
module sreg_bank
  import sreg_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              st_we,
  input  logic [IDX_W-1:0]  st_idx,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic [BYTE_W-1:0] st_data,
  input  logic              commit,
  input  logic              drop,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [BYTE_W-1:0] rd_byte,
  output logic [15:0]       data_word,
  output logic [15:0]       cmd_word,
  output logic [23:0]       ofs_word,
  output logic [23:0]       fsc_word
);
  logic [MAX_XFER-1:0]  stg_v;
  logic [ADDR_W-1:0]    stg_a [MAX_XFER];
  logic [BYTE_W-1:0]    stg_d [MAX_XFER];
  logic [NLOC-1:0][BYTE_W-1:0] bank;

  always_ff @(posedge clk) begin
    if (rst || drop || commit) begin
      stg_v <= '0;
    end else if (st_we) begin
      stg_v[st_idx] <= 1'b1;
      stg_a[st_idx] <= st_addr;
      stg_d[st_idx] <= st_data;
    end
  end

  for (genvar g = 0; g < NLOC; g++) begin : g_loc
    logic [BYTE_W-1:0] q;
    if (loc_mapped(ADDR_W'(g))) begin : g_reg
      always_ff @(posedge clk) begin
        if (rst) begin
          q <= '0;
        end else if (commit) begin
          for (int k = 0; k < MAX_XFER; k++)
            if (stg_v[k] && stg_a[k] == ADDR_W'(g)) q <= stg_d[k];
        end
      end
    end else begin : g_rsv
      assign q = '0;
    end
    assign bank[g] = q;
  end

  assign rd_byte   = bank[rd_addr];
  assign data_word = {bank[0], bank[1]};
  assign cmd_word  = {bank[4], bank[5]};
  assign ofs_word  = {bank[8], bank[9], bank[10]};
  assign fsc_word  = {bank[12], bank[13], bank[14]};
endmodule

// File: rtl/sreg_port_slave.sv
module sreg_port_slave
  import sreg_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int TIMEOUT_CYC = 250000,
  localparam int CNT_W = $clog2(TIMEOUT_CYC + 1)
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        sclk,
  input  logic        cs_n,
  input  logic        sdio_in,
  output logic        sdio_out,
  output logic        sdio_oe,
  output logic [15:0] data_word,
  output logic [15:0] cmd_word,
  output logic [23:0] ofs_word,
  output logic [23:0] fsc_word
);
  logic rise, fall, din, abort_w, busy, commit_w, drop_w, st_we;
  logic [IDX_W-1:0]  st_idx;
  logic [ADDR_W-1:0] st_addr, rd_addr;
  logic [BYTE_W-1:0] st_data, rd_byte;
  logic [CNT_W-1:0]  stall_cnt;

  sreg_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .sclk(sclk), .cs_n(cs_n), .sdio_in(sdio_in),
    .rise(rise), .fall(fall), .din(din));

  sreg_stall_timer #(.LIMIT(TIMEOUT_CYC)) u_timer (
    .clk(clk), .rst(rst), .busy(busy), .edge_seen(rise || fall),
    .abort(abort_w), .cnt(stall_cnt));

  sreg_engine u_eng (
    .clk(clk), .rst(rst), .rise(rise), .fall(fall), .din(din), .abort(abort_w),
    .lsb_first(cmd_word[CMD_LSB_FIRST]), .addr_down(cmd_word[CMD_ADDR_DOWN]),
    .rd_byte(rd_byte), .rd_addr(rd_addr), .st_we(st_we), .st_idx(st_idx),
    .st_addr(st_addr), .st_data(st_data), .commit(commit_w), .drop(drop_w),
    .busy(busy), .sdio_out(sdio_out), .sdio_oe(sdio_oe));

  sreg_bank u_bank (
    .clk(clk), .rst(rst), .st_we(st_we), .st_idx(st_idx), .st_addr(st_addr),
    .st_data(st_data), .commit(commit_w), .drop(drop_w), .rd_addr(rd_addr),
    .rd_byte(rd_byte), .data_word(data_word), .cmd_word(cmd_word),
    .ofs_word(ofs_word), .fsc_word(fsc_word));
endmodule

// File: rtl/sreg_port_chk.sv
module sreg_port_chk #(
  parameter int LIMIT = 250000,
  localparam int CNT_W = $clog2(LIMIT + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             busy,
  input logic             abort_w,
  input logic             commit_w,
  input logic             sdio_oe,
  input logic [CNT_W-1:0] stall_cnt,
  input logic [15:0]      data_word,
  input logic [15:0]      cmd_word,
  input logic [23:0]      ofs_word,
  input logic [23:0]      fsc_word
);
  assert_oe_in_xfer_R8: assert property (@(posedge clk) disable iff (rst)
    sdio_oe |-> busy);

  assert_abort_release_R7: assert property (@(posedge clk) disable iff (rst)
    abort_w |=> (!sdio_oe && !busy));

  assert_regs_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !commit_w |=> $stable({data_word, cmd_word, ofs_word, fsc_word}));

  assert_commit_idle_R6: assert property (@(posedge clk) disable iff (rst)
    commit_w |-> !busy);

  assert_stall_bound_R7: assert property (@(posedge clk) disable iff (rst)
    stall_cnt < CNT_W'(LIMIT));
endmodule

bind sreg_port_slave sreg_port_chk #(.LIMIT(TIMEOUT_CYC)) u_chk (
  .clk(clk), .rst(rst), .busy(busy), .abort_w(abort_w), .commit_w(commit_w),
  .sdio_oe(sdio_oe), .stall_cnt(stall_cnt), .data_word(data_word),
  .cmd_word(cmd_word), .ofs_word(ofs_word), .fsc_word(fsc_word));

// File: tb/sreg_port_slave_test.sv
module sreg_port_slave_test;
  localparam int TMO = 300;

  logic clk = 1'b0, rst = 1'b1, sclk = 1'b0, cs_n = 1'b0, sdio_in = 1'b0;
  logic sdio_out, sdio_oe;
  logic [15:0] data_word, cmd_word;
  logic [23:0] ofs_word, fsc_word;
  int n_run = 0, n_fail = 0;
  logic [7:0] m [16];

  always #4 clk = ~clk;

  sreg_port_slave #(.SYNC_STAGES(2), .TIMEOUT_CYC(TMO)) uut (.*);

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int flen(input logic [1:0] f);
    return (f == 2'b11) ? 3 : int'(f) + 1;
  endfunction

  function automatic logic mapped(input logic [3:0] a);
    return a inside {4'd0, 4'd1, 4'd4, 4'd5, 4'd8, 4'd9, 4'd10, 4'd12, 4'd13, 4'd14};
  endfunction

  function automatic logic [3:0] step(input logic [3:0] a);
    return m[5][2] ? a - 4'd1 : a + 4'd1;
  endfunction

  task automatic sbit(input logic b, output logic o, output logic e);
    sdio_in = b;
    wait_cyc(4);
    sclk = 1'b1;
    wait_cyc(8);
    o = sdio_out;
    e = sdio_oe;
    sclk = 1'b0;
    wait_cyc(4);
  endtask

  task automatic send_byte_msb(input logic [7:0] b);
    logic o, e;
    for (int i = 7; i >= 0; i--) sbit(b[i], o, e);
  endtask

  task automatic check_words(input string tag);
    chk({tag, " R2 data_word"}, 32'(data_word), 32'({m[0], m[1]}));
    chk({tag, " R2 cmd_word"},  32'(cmd_word),  32'({m[4], m[5]}));
    chk({tag, " R2 ofs_word"},  32'(ofs_word),  32'({m[8], m[9], m[10]}));
    chk({tag, " R2 fsc_word"},  32'(fsc_word),  32'({m[12], m[13], m[14]}));
  endtask

  task automatic xfer(input logic [7:0] ib, input logic [2:0][7:0] wb, input string tag);
    int n, bad_oe;
    logic [3:0] a;
    logic lsb, o, e;
    logic [7:0] rb;
    logic [3:0] st_a [3];
    logic [7:0] st_d [3];
    n = flen(ib[6:5]);
    lsb = m[5][3];
    a = ib[3:0];
    bad_oe = 0;
    send_byte_msb(ib);
    for (int k = 0; k < n; k++) begin
      rb = '0;
      for (int j = 0; j < 8; j++) begin
        int bp;
        bp = lsb ? j : 7 - j;
        sbit(wb[k][bp], o, e);
        rb[bp] = o;
        if (e !== ib[7]) bad_oe++;
      end
      if (ib[7]) chk({tag, " R1 R2 R3 R4 R5 read byte"}, 32'(rb), 32'(m[a]));
      st_a[k] = a;
      st_d[k] = wb[k];
      a = step(a);
    end
    chk({tag, " R8 oe during data"}, bad_oe, 0);
    wait_cyc(2);
    chk({tag, " R8 oe released"}, 32'(sdio_oe), 0);
    if (!ib[7])
      for (int k = 0; k < n; k++) if (mapped(st_a[k])) m[st_a[k]] = st_d[k];
    wait_cyc(8);
    if (!ib[7]) check_words(tag);
  endtask

  initial begin
    wait_cyc(200000);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic o, e;
    void'($urandom(32'd4242));
    for (int i = 0; i < 16; i++) m[i] = 8'h00;
    wait_cyc(5);
    // R10: reset state
    chk("R10 reset oe", 32'(sdio_oe), 0);
    check_words("R10 reset");
    rst = 1'b0;
    wait_cyc(4);
    check_words("R10 after reset");

    // R1: write 2 bytes to data, bit 4 of instruction set (ignored)
    xfer(8'b0011_0000, {8'h00, 8'h34, 8'h12}, "R1 two-byte write");
    chk("R1 data value", 32'(data_word), 32'h1234);
    // R1: length code 11 moves 3 bytes
    xfer(8'b0110_1100, {8'hC3, 8'hB2, 8'hA1}, "R1 len11 write");
    chk("R1 fsc value", 32'(fsc_word), 32'hA1B2C3);
    // R2: reserved write ignored, read back 0
    xfer(8'b0000_0010, {8'h00, 8'h00, 8'h5A}, "R2 reserved write");
    xfer(8'b1010_0010, '0, "R2 reserved read");

    // R5: first read bit presented after instruction, before any rising edge
    send_byte_msb(8'b1000_0000);
    wait_cyc(4);
    chk("R5 oe after instr", 32'(sdio_oe), 1);
    chk("R5 first bit", 32'(sdio_out), 32'(m[0][7]));
    for (int j = 7; j >= 0; j--) sbit(1'b0, o, e);
    wait_cyc(4);

    // R6: three-byte offset write, nothing lands before the last bit
    send_byte_msb(8'b0100_1000);
    send_byte_msb(8'h11);
    send_byte_msb(8'h22);
    for (int j = 7; j >= 1; j--) sbit(j[0], o, e);
    wait_cyc(8);
    chk("R6 ofs before last bit", 32'(ofs_word), 0);
    sbit(1'b0, o, e);
    wait_cyc(8);
    chk("R6 ofs after last bit", 32'(ofs_word), 32'h1122AA);
    m[8] = 8'h11; m[9] = 8'h22; m[10] = 8'hAA;

    // R7: stall mid-write drops staged bytes
    send_byte_msb(8'b0010_0000);
    send_byte_msb(8'hEE);
    for (int j = 0; j < 3; j++) sbit(1'b1, o, e);
    wait_cyc(TMO + 100);
    chk("R7 data kept after stall", 32'(data_word), 32'h1234);
    xfer(8'b1000_0001, '0, "R7 new instr after stall");
    // R7: stall mid-read releases the line
    send_byte_msb(8'b1010_1000);
    for (int j = 0; j < 3; j++) sbit(1'b0, o, e);
    chk("R7 oe during read", 32'(sdio_oe), 1);
    wait_cyc(TMO + 100);
    chk("R7 oe after stall", 32'(sdio_oe), 0);

    // R8: raising cs_n mid-read keeps driving
    send_byte_msb(8'b1000_0001);
    for (int j = 0; j < 2; j++) sbit(1'b0, o, e);
    cs_n = 1'b1;
    wait_cyc(8);
    chk("R8 oe with cs_n high", 32'(sdio_oe), 1);
    cs_n = 1'b0;
    wait_cyc(4);
    for (int j = 0; j < 6; j++) sbit(1'b0, o, e);
    wait_cyc(4);
    chk("R8 oe after read end", 32'(sdio_oe), 0);

    // R9: edges ignored while deselected
    cs_n = 1'b1;
    wait_cyc(4);
    send_byte_msb(8'b0000_0000);
    send_byte_msb(8'hFF);
    cs_n = 1'b0;
    wait_cyc(8);
    chk("R9 data unchanged", 32'(data_word), 32'h1234);
    xfer(8'b1010_0000, '0, "R9 idle after deselect");

    // R3: wrap upward past 15
    xfer(8'b0010_1111, {8'h00, 8'h77, 8'h99}, "R3 wrap up");
    chk("R3 wrap data", 32'(data_word), 32'h7734);
    // R3: downward stepping
    xfer(8'b0000_0101, {8'h00, 8'h00, 8'h04}, "R3 set down");
    xfer(8'b0010_0001, {8'h00, 8'hC0, 8'h0D}, "R3 down write");
    chk("R3 down data", 32'(data_word), 32'hC00D);
    // R4: LSB-first data
    xfer(8'b0000_0101, {8'h00, 8'h00, 8'h08}, "R4 set lsb");
    xfer(8'b0000_0000, {8'h00, 8'h00, 8'h81}, "R4 lsb write");
    chk("R4 lsb data", 32'(data_word[15:8]), 32'h81);
    xfer(8'b1000_0000, '0, "R4 lsb read");

    // random exchanges, command word rewritten along the way
    for (int t = 0; t < 120; t++) begin
      logic [7:0] ib;
      logic [2:0][7:0] wb;
      ib = 8'($urandom);
      wb = 24'($urandom);
      xfer(ib, wb, "R3 R4 random");
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule